// File: doc/BRIEF.md
# Running-Disparity Lane Balancer

This block sits between the stage that forms lane words and the serializer. Each of its lanes receives a narrow data word in every valid cycle. The lane either passes the word through unchanged or replaces it with its bitwise complement. It then adds one flag bit that records which of the two it chose. The choice limits the DC bias that builds up on each lane. A signed running count per lane tracks the bias: the number of ones sent minus the number of zeros sent, with the flag bit counted as well.

The running count is clamped to a range that is not symmetric about zero: it never goes above +7 and never goes below -6. The lane compares the sign of its running count with the sign of the incoming word's disparity to decide whether to invert. A disparity of zero on the word counts as "not positive". A running count of zero always causes inversion. A single enable input turns balancing off for all lanes. While balancing is off, the words pass through unchanged with a zero flag bit, and every running count keeps its value. The output registers hold one symbol per lane and update one clock after each valid input.

Top module: `dcb_balancer`

## Requirements
- R1: While `rst` is high, and after it is released, `out_valid` is 0, `out_syms` is all zeros and every lane's running disparity is 0.
- R2: `out_valid` equals the `in_valid` of the previous cycle. A valid input appears on `out_syms` exactly one clock later.
- R3: When `bal_en` is 0, each lane symbol is the input word with a 0 flag bit, and the running disparities are left unchanged.
- R4: With `bal_en` high and a lane's running disparity equal to 0, the lane inverts its word whatever the word's disparity.
- R5: With `bal_en` high and a positive running disparity, the lane inverts the word only if the word's disparity (ones minus zeros) is positive.
- R6: With `bal_en` high and a negative running disparity, the lane inverts the word only if the word's disparity is zero or negative.
- R7: Lane i takes input bits [6i+5:6i] and drives output bits [7i+6:7i]. Output bit 7i+6 is the flag: 1 means inverted, 0 means unchanged. Bits [7i+5:7i] hold the word or its complement, so that the flag XOR-ed into the data gives back the input word.
- R8: On a balanced valid cycle the running disparity changes by d-1 when the word is sent unchanged and by 1-d when it is inverted, where d is the word's disparity.
- R9: The running disparity is clamped to the range -6 to +7.
- R10: In a cycle with `in_valid` low, the running disparities and `out_syms` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bal_en | input | 1 | Enables balancing on all lanes |
| in_valid | input | 1 | Marks a cycle whose lane words are to be encoded |
| in_words | input | 48 | Eight 6-bit lane words, lane 0 in the low bits |
| out_valid | output | 1 | Marks a cycle whose symbols are new |
| out_syms | output | 56 | Eight 7-bit lane symbols (flag in the top bit of each) |

## Verification
The hardest state to reach from the ports is a running disparity at one of its extremes. Reaching -6 needs a running count of exactly +1 followed by an all-zero word. Reaching +7 needs an all-zero word arriving while the count is zero. Random words almost never form these chains on a given lane. The stimulus therefore includes directed sequences that build each chain on all lanes at once: a balanced word, then an all-zero word, then the same word again. Random traffic with the enable and valid inputs toggling then covers the hold behaviour while the bench's model tracks each lane's count.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned WORD_W_DEF = 6;
  localparam int unsigned RD_W_DEF = 4;
  localparam int RD_MAX_DEF = 7;
  localparam int RD_MIN_DEF = -6;
endpackage

// File: rtl/dcb_word_disp.sv
module dcb_word_disp #(
  parameter int unsigned WORD_W = 6,
  localparam int unsigned CW = $clog2(WORD_W + 1),
  localparam int unsigned SW = CW + 2
) (
  input  logic [WORD_W-1:0]    word,
  output logic signed [SW-1:0] disp
);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int b = 0; b < WORD_W; b++) ones = ones + CW'(word[b]);
  end

  // ones minus zeros = 2*ones - WORD_W
  assign disp = $signed({1'b0, ones, 1'b0}) - $signed(SW'(WORD_W));
endmodule

// File: rtl/dcb_lane.sv
module dcb_lane #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned RD_W = 4,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6,
  localparam int unsigned CW = $clog2(WORD_W + 1),
  localparam int unsigned SW = CW + 2,
  localparam int unsigned XW = ((RD_W > SW) ? RD_W : SW) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bal_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W:0]   sym
);
  localparam logic signed [SW-1:0] ONE = SW'(1);
  localparam logic signed [XW-1:0] SAT_HI = XW'(RD_MAX);
  localparam logic signed [XW-1:0] SAT_LO = XW'(RD_MIN);

  logic signed [RD_W-1:0] rd_q;
  logic signed [SW-1:0]   disp;
  logic signed [SW-1:0]   delta;
  logic signed [XW-1:0]   sum;
  logic signed [RD_W-1:0] rd_nxt;
  logic rd_zero, rd_neg, rd_pos, d_pos, invert;

  dcb_word_disp #(.WORD_W(WORD_W)) u_disp (.word(word), .disp(disp));

  assign rd_zero = (rd_q == '0);
  assign rd_neg  = rd_q[RD_W-1];
  assign rd_pos  = !rd_neg && !rd_zero;
  assign d_pos   = !disp[SW-1] && (disp != '0);
  assign invert  = bal_en && (rd_zero || (rd_pos && d_pos) || (rd_neg && !d_pos));
  assign delta   = invert ? (ONE - disp) : (disp - ONE);
  assign sum     = XW'(rd_q) + XW'(delta);

  always_comb begin
    if (sum > SAT_HI)      rd_nxt = RD_W'(SAT_HI);
    else if (sum < SAT_LO) rd_nxt = RD_W'(SAT_LO);
    else                   rd_nxt = RD_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      sym  <= '0;
    end else if (in_valid) begin
      sym <= {invert, invert ? ~word : word};
      if (bal_en) rd_q <= rd_nxt;
    end
  end
endmodule

// File: rtl/dcb_balancer.sv
module dcb_balancer
  import dcb_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned RD_W = RD_W_DEF,
  parameter int RD_MAX = RD_MAX_DEF,
  parameter int RD_MIN = RD_MIN_DEF,
  localparam int unsigned SYM_W = WORD_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bal_en,
  input  logic                      in_valid,
  input  logic [LANES*WORD_W-1:0]   in_words,
  output logic                      out_valid,
  output logic [LANES*SYM_W-1:0]    out_syms
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dcb_lane #(
      .WORD_W(WORD_W), .RD_W(RD_W), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)
    ) u_lane (
      .clk(clk), .rst(rst), .bal_en(bal_en), .in_valid(in_valid),
      .word(in_words[i*WORD_W +: WORD_W]),
      .sym(out_syms[i*SYM_W +: SYM_W])
    );
  end
endmodule

// File: rtl/dcb_balancer_chk.sv
module dcb_balancer_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WORD_W = 6,
  localparam int unsigned SYM_W = WORD_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bal_en,
  input logic                    in_valid,
  input logic [LANES*WORD_W-1:0] in_words,
  input logic                    out_valid,
  input logic [LANES*SYM_W-1:0]  out_syms
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_syms == '0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(out_syms));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_pass_disabled_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !bal_en) |=>
        (out_syms[i*SYM_W +: SYM_W] == {1'b0, $past(in_words[i*WORD_W +: WORD_W])}));

    assert_round_trip_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=>
        ((out_syms[i*SYM_W +: WORD_W] ^ {WORD_W{out_syms[i*SYM_W + WORD_W]}})
          == $past(in_words[i*WORD_W +: WORD_W])));
  end
endmodule

bind dcb_balancer dcb_balancer_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .bal_en(bal_en), .in_valid(in_valid),
  .in_words(in_words), .out_valid(out_valid), .out_syms(out_syms)
);

// File: tb/sim_dcb_balancer.sv
module sim_dcb_balancer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int W = 6;
  localparam int SW = W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bal_en = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES*W-1:0] in_words = '0;
  logic out_valid;
  logic [LANES*SW-1:0] out_syms;

  int n_checks = 0;
  int n_fail = 0;
  int rd_m [LANES];
  logic [LANES*SW-1:0] last_syms;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcb_balancer u0 (
    .clk(clk), .rst(rst), .bal_en(bal_en), .in_valid(in_valid),
    .in_words(in_words), .out_valid(out_valid), .out_syms(out_syms)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of one lane: returns symbol, updates the model running disparity
  function automatic logic [SW-1:0] model_lane(input int lane, input logic en,
                                               input logic [W-1:0] w);
    int ones = 0;
    int d, rd, nx;
    logic inv;
    for (int b = 0; b < W; b++) ones += int'(w[b]);
    d = 2*ones - W;
    rd = rd_m[lane];
    if (!en) inv = 1'b0;                // R3
    else if (rd == 0) inv = 1'b1;       // R4
    else if (rd > 0) inv = (d > 0);     // R5
    else inv = (d <= 0);                // R6
    if (en) begin
      nx = inv ? rd + 1 - d : rd + d - 1;  // R8
      if (nx > 7) nx = 7;                  // R9
      if (nx < -6) nx = -6;
      rd_m[lane] = nx;
    end
    return {inv, inv ? ~w : w};            // R7
  endfunction

  task automatic step(input string req, input logic en, input logic v,
                      input logic [LANES*W-1:0] words);
    logic [LANES*SW-1:0] exp;
    @(negedge clk);
    bal_en = en; in_valid = v; in_words = words;
    exp = last_syms;
    if (v) for (int l = 0; l < LANES; l++)
      exp[l*SW +: SW] = model_lane(l, en, words[l*W +: W]);
    @(posedge clk); #1;
    check("R2 out_valid", 64'(out_valid), 64'(v));
    check(v ? req : "R10 hold", 64'(out_syms), 64'(exp));
    if (v) for (int l = 0; l < LANES; l++)
      check("R7 decode", 64'(out_syms[l*SW +: W] ^ {W{out_syms[l*SW+W]}}),
            64'(words[l*W +: W]));
    last_syms = exp;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < LANES; l++) rd_m[l] = 0;
    last_syms = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset syms", 64'(out_syms), 64'd0);
    @(negedge clk); rst = 1'b0;

    // R4: zero disparity inverts even a balanced word; rd -> +1
    step("R4 zero rd invert", 1'b1, 1'b1, {LANES{6'b000111}});
    // R5: positive rd, negative word passes; rd 1 + (-7) -> -6 (R9 floor)
    step("R5 pos rd pass", 1'b1, 1'b1, {LANES{6'b000000}});
    // R10: idle cycle, R3: disabled words pass and rd is held at -6
    step("R10 idle", 1'b1, 1'b0, {LANES{6'b101010}});
    step("R3 disabled pass", 1'b0, 1'b1, {LANES{6'b000000}});
    step("R3 disabled pass", 1'b0, 1'b1, {LANES{6'b111111}});
    // R6: at -6 an all-zero word inverts; rd -> +1
    step("R6 neg rd invert", 1'b1, 1'b1, {LANES{6'b000000}});
    // R5: positive rd, positive word inverts; rd 1 + (1-6) -> -4
    step("R5 pos rd invert", 1'b1, 1'b1, {LANES{6'b111111}});
    // R6: negative rd, positive word passes; rd -4 + 3 -> -1
    step("R6 neg rd pass", 1'b1, 1'b1, {LANES{6'b111110}});
    // R8: negative rd, all-zero word inverted; rd -1 + 7 -> 6
    step("R8 update", 1'b1, 1'b1, {LANES{6'b000000}});
    step("R8 update", 1'b1, 1'b1, {LANES{6'b011000}});

    // R1: reset mid-run clears the running disparity
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 reset again", 64'(out_syms), 64'd0);
    @(negedge clk); rst = 1'b0;
    for (int l = 0; l < LANES; l++) rd_m[l] = 0;
    last_syms = '0;
    // R9: +7 ceiling reached from zero with an all-zero word
    step("R9 ceiling", 1'b1, 1'b1, {LANES{6'b000000}});
    step("R9 ceiling hold", 1'b1, 1'b1, {LANES{6'b001000}});

    for (int k = 0; k < 400; k++) begin
      logic [LANES*W-1:0] w;
      for (int l = 0; l < LANES; l++) w[l*W +: W] = 6'($urandom);
      step("R5 R6 R8 random", ($urandom % 5) != 0, ($urandom % 4) != 0, w);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule